// File: doc/BRIEF.md
# Predicated Saturating Vector Shifter

This block shifts every lane of a packed vector of signed integers by its own signed amount and clamps each result to the lane's signed range. A two-bit selector sets the lane width to 8, 16, 32 or 64 bits. The vector width is a parameter and must be a multiple of 64. The shift amounts come from a second operand vector, and that same operand is the one the result overwrites. A lane whose predicate is clear therefore returns its own shift amount unchanged.

A positive amount shifts left and saturates. A zero or negative amount performs an arithmetic right shift by the magnitude, which rounds toward minus infinity. Each amount is clamped before it is applied, so any large amount gives a defined result. Each lane reports whether its result was saturated. The block has a single register stage: an operation captured with `in_valid` appears on the outputs one cycle later with `out_valid`.

Top module: `pred_sat_shifter`

## Requirements
- R1: `size_sel` selects the lane width N: 2'b00 gives 8, 2'b01 gives 16, 2'b10 gives 32 and 2'b11 gives 64 bits. Lane k occupies bits [k*N +: N] of every vector, and there are VLEN/N lanes.
- R2: In an active lane, an amount A > 0 read from `amt_vec` shifts the `src_vec` lane left by A. When the result fits in N signed bits, it appears unchanged in the same lane of `out_vec`.
- R3: In an active lane, an amount A <= 0 gives an arithmetic right shift of the `src_vec` lane by -A, rounded toward minus infinity. An amount of 0 returns the source value unchanged.
- R4: An active lane whose left-shifted value is above 2^(N-1)-1 outputs 2^(N-1)-1. One below -2^(N-1) outputs -2^(N-1).
- R5: The amount is read as a signed N-bit value and clamped to [-(N+1), N+1]. A right shift by N or more gives 0 for a non-negative source and -1 for a negative source. A left shift of zero gives zero. Any nonzero source shifted left by N or more saturates according to its sign.
- R6: A lane is active when `pred` bit k*N/8 is set, which is the bit of the lane's lowest byte. The other predicate bits of the lane have no effect. An inactive lane outputs its `amt_vec` lane unchanged.
- R7: `out_sat` bit k*N/8 is set exactly when active lane k saturated. All other `out_sat` bits are 0, and so is the bit of every inactive lane.
- R8: Inputs are captured on a rising edge with `in_valid` high. Their results appear on the next cycle with `out_valid` high. After a cycle without `in_valid`, `out_valid` is low and `out_vec`/`out_sat` hold their previous values.
- R9: While `rst_n` is low at a rising edge, `out_valid`, `out_vec` and `out_sat` are cleared to 0 on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Capture operands this cycle |
| size_sel | input | 2 | Lane width selector |
| src_vec | input | VLEN | Values to shift |
| amt_vec | input | VLEN | Per-lane signed shift amounts; pass-through value for inactive lanes |
| pred | input | VLEN/8 | Predicate, one bit per byte |
| out_valid | output | 1 | Result valid |
| out_vec | output | VLEN | Result vector |
| out_sat | output | VLEN/8 | Saturation flags at each lane's lowest byte |

## Verification
Every lane's result passes through one output register. A wrong clamp, a wrong shift direction or a wrong saturation compare therefore shows up in the first cycle with `out_valid` high after the faulty input, in the lane concerned and its flag bit. A predicate bit read from the wrong byte, or a lane boundary in the wrong place, shows up in that same cycle as a lane that should have kept its amount but did not, or the reverse. A broken capture enable shows up one cycle later, as results that change during an idle cycle or a valid flag that does not follow `in_valid`.

// File: rtl/pss_pkg.sv
// Shared definitions for the predicated saturating shifter.
// Assumes vectors are split into 64-bit chunks that never share a lane.
package pss_pkg;
    localparam int CHUNK_W = 64;
    localparam int CHUNK_B = CHUNK_W / 8;

    typedef enum logic [1:0] {
        ESZ_BYTE = 2'b00,
        ESZ_HALF = 2'b01,
        ESZ_WORD = 2'b10,
        ESZ_DBL  = 2'b11
    } esize_e;
endpackage

// File: rtl/pss_lane.sv
// One lane of width W: clamps the signed amount, then either shifts left
// with signed saturation or shifts right arithmetically. An inactive lane
// returns its amount operand. Assumes W is 8, 16, 32 or 64.
module pss_lane #(
    parameter int W = 8
) (
    input  logic         act,
    input  logic [W-1:0] val,
    input  logic [W-1:0] amt,
    output logic [W-1:0] res,
    output logic         ovf
);
    localparam int EW = W + 2;
    localparam int XW = 2 * W + 2;
    localparam logic signed [EW-1:0] LIM  = EW'(W + 1);
    localparam logic signed [XW-1:0] MAXW = {{(W+3){1'b0}}, {(W-1){1'b1}}};
    localparam logic signed [XW-1:0] MINW = {{(W+3){1'b1}}, {(W-1){1'b0}}};
    localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    logic signed [EW-1:0] a_ext, a_clip, a_neg;
    logic                 go_left;
    logic [6:0]           lsh, rsh;
    logic signed [XW-1:0] wide;
    logic signed [W-1:0]  right_res;
    logic                 too_big, too_small;

    // Clamp the signed amount to +/-(W+1) and split it into two shift counts.
    always_comb begin
        a_ext = EW'($signed(amt));
        if (a_ext > LIM)
            a_clip = LIM;
        else if (a_ext < -LIM)
            a_clip = -LIM;
        else
            a_clip = a_ext;
        a_neg   = -a_clip;
        go_left = (a_clip > 0);
        lsh     = go_left ? a_clip[6:0] : 7'd0;
        rsh     = go_left ? 7'd0 : a_neg[6:0];
    end

    // Exact left result in a wide field, and the arithmetic right result.
    always_comb begin
        wide      = XW'($signed(val)) <<< lsh;
        too_big   = (wide > MAXW);
        too_small = (wide < MINW);
        right_res = $signed(val) >>> rsh;
    end

    // Pick the lane result and its saturation flag.
    always_comb begin
        ovf = 1'b0;
        if (!act) begin
            res = amt;
        end else if (go_left) begin
            if (too_big) begin
                res = MAXV;
                ovf = 1'b1;
            end else if (too_small) begin
                res = MINV;
                ovf = 1'b1;
            end else begin
                res = wide[W-1:0];
            end
        end else begin
            res = right_res;
        end
    end
endmodule

// File: rtl/pss_chunk.sv
// One 64-bit chunk: builds the lanes for all four widths and selects the
// set named by size_sel. A lane's predicate and flag sit at its lowest byte.
module pss_chunk
    import pss_pkg::*;
(
    input  logic [1:0]         size_sel,
    input  logic [CHUNK_W-1:0] val,
    input  logic [CHUNK_W-1:0] amt,
    input  logic [CHUNK_B-1:0] pred,
    output logic [CHUNK_W-1:0] res,
    output logic [CHUNK_B-1:0] sat
);
    logic [3:0][CHUNK_W-1:0] res_k;
    logic [3:0][CHUNK_B-1:0] sat_k;

    for (genvar k = 0; k < 4; k++) begin : g_width
        localparam int W  = 8 << k;
        localparam int NL = CHUNK_W / W;
        localparam int BP = W / 8;
        logic [NL-1:0]      ovf_l;
        logic [CHUNK_W-1:0] res_w;

        for (genvar l = 0; l < NL; l++) begin : g_lane
            pss_lane #(.W(W)) u_lane (
                .act (pred[l*BP]),
                .val (val[l*W +: W]),
                .amt (amt[l*W +: W]),
                .res (res_w[l*W +: W]),
                .ovf (ovf_l[l])
            );
        end

        // Place each lane flag at its lowest byte position.
        always_comb begin
            sat_k[k] = '0;
            for (int l = 0; l < NL; l++)
                sat_k[k][l*BP] = ovf_l[l];
        end

        assign res_k[k] = res_w;
    end

    // Select the lane width in use.
    always_comb begin
        case (esize_e'(size_sel))
            ESZ_BYTE: begin res = res_k[0]; sat = sat_k[0]; end
            ESZ_HALF: begin res = res_k[1]; sat = sat_k[1]; end
            ESZ_WORD: begin res = res_k[2]; sat = sat_k[2]; end
            default:  begin res = res_k[3]; sat = sat_k[3]; end
        endcase
    end
endmodule

// File: rtl/pss_out_reg.sv
// Output stage: loads result and flags when in_valid is high, holds them
// otherwise; out_valid follows in_valid. Synchronous active-low reset.
module pss_out_reg #(
    parameter int VLEN = 128,
    parameter int NB   = VLEN / 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [VLEN-1:0] d_vec,
    input  logic [NB-1:0]   d_sat,
    output logic            out_valid,
    output logic [VLEN-1:0] out_vec,
    output logic [NB-1:0]   out_sat
);
    // Register the result on a valid cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_vec   <= '0;
            out_sat   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_vec <= d_vec;
                out_sat <= d_sat;
            end
        end
    end
endmodule

// File: rtl/pred_sat_shifter.sv
// Top: splits the vector into 64-bit chunks, shifts every lane in parallel
// and registers the result. Assumes VLEN is a multiple of 64.
module pred_sat_shifter
    import pss_pkg::*;
#(
    parameter int VLEN = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        size_sel,
    input  logic [VLEN-1:0]   src_vec,
    input  logic [VLEN-1:0]   amt_vec,
    input  logic [VLEN/8-1:0] pred,
    output logic              out_valid,
    output logic [VLEN-1:0]   out_vec,
    output logic [VLEN/8-1:0] out_sat
);
    localparam int NB  = VLEN / 8;
    localparam int NCH = VLEN / CHUNK_W;

    logic [VLEN-1:0] comb_vec;
    logic [NB-1:0]   comb_sat;

    for (genvar c = 0; c < NCH; c++) begin : g_chunk
        pss_chunk u_chunk (
            .size_sel (size_sel),
            .val      (src_vec[c*CHUNK_W +: CHUNK_W]),
            .amt      (amt_vec[c*CHUNK_W +: CHUNK_W]),
            .pred     (pred[c*CHUNK_B +: CHUNK_B]),
            .res      (comb_vec[c*CHUNK_W +: CHUNK_W]),
            .sat      (comb_sat[c*CHUNK_B +: CHUNK_B])
        );
    end

    pss_out_reg #(.VLEN(VLEN), .NB(NB)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .d_vec     (comb_vec),
        .d_sat     (comb_sat),
        .out_valid (out_valid),
        .out_vec   (out_vec),
        .out_sat   (out_sat)
    );
endmodule

// File: rtl/pss_checker.sv
// Port-level checks for pred_sat_shifter. Keeps its own copy of the
// captured size, predicate and amounts to judge each registered result.
module pss_checker #(
    parameter int VLEN = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [1:0]        size_sel,
    input logic [VLEN-1:0]   amt_vec,
    input logic [VLEN/8-1:0] pred,
    input logic              out_valid,
    input logic [VLEN-1:0]   out_vec,
    input logic [VLEN/8-1:0] out_sat
);
    localparam int NB = VLEN / 8;

    logic [1:0]      cap_size;
    logic [NB-1:0]   cap_pred;
    logic [VLEN-1:0] cap_amt;
    logic [NB-1:0]   act_b, low_b;

    // Hold the operands of the operation now on the outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_size <= '0;
            cap_pred <= '0;
            cap_amt  <= '0;
        end else if (in_valid) begin
            cap_size <= size_sel;
            cap_pred <= pred;
            cap_amt  <= amt_vec;
        end
    end

    // Per byte: is its lane active, and is it the lane's lowest byte.
    always_comb begin
        for (int b = 0; b < NB; b++) begin
            int m;
            m        = (1 << cap_size) - 1;
            act_b[b] = cap_pred[b & ~m];
            low_b[b] = ((b & m) == 0);
        end
    end

    assert_valid_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_vec) && $stable(out_sat)));
    assert_reset_clear_R9: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_vec == '0 && out_sat == '0));

    for (genvar b = 0; b < NB; b++) begin : g_byte
        assert_inactive_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && !act_b[b]) |-> (out_vec[b*8 +: 8] == cap_amt[b*8 +: 8]));
        assert_flag_place_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && out_sat[b]) |-> (act_b[b] && low_b[b]));
        assert_byte_sat_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && out_sat[b] && cap_size == 2'b00) |->
            (out_vec[b*8 +: 8] == 8'h7F || out_vec[b*8 +: 8] == 8'h80));
    end
endmodule

bind pred_sat_shifter pss_checker #(.VLEN(VLEN)) u_pss_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .size_sel  (size_sel),
    .amt_vec   (amt_vec),
    .pred      (pred),
    .out_valid (out_valid),
    .out_vec   (out_vec),
    .out_sat   (out_sat)
);

// File: tb/tb_pred_sat_shifter.sv
module tb_pred_sat_shifter;
    localparam int VLEN = 128;
    localparam int NB   = VLEN / 8;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            in_valid;
    logic [1:0]      size_sel;
    logic [VLEN-1:0] src_vec, amt_vec;
    logic [NB-1:0]   pred;
    logic            out_valid;
    logic [VLEN-1:0] out_vec;
    logic [NB-1:0]   out_sat;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    running = 1'b0;
    string cur_tag = "R9";

    always #4 clk = ~clk;

    pred_sat_shifter #(.VLEN(VLEN)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .size_sel(size_sel),
        .src_vec(src_vec), .amt_vec(amt_vec), .pred(pred),
        .out_valid(out_valid), .out_vec(out_vec), .out_sat(out_sat)
    );

    function automatic logic [63:0] lmask(input int w);
        return (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    endfunction

    // Behavioural lane model using wide integers.
    function automatic void ref_lane(input int w, input logic [63:0] vr, input logic [63:0] ar,
                                     output logic [63:0] r, output logic s);
        longint vl, al, lim;
        logic signed [131:0] big, mx, mn;
        vl  = $signed(vr << (64 - w)) >>> (64 - w);
        al  = $signed(ar << (64 - w)) >>> (64 - w);
        lim = w + 1;
        if (al > lim) al = lim;
        if (al < -lim) al = -lim;
        s = 1'b0;
        if (al > 0) begin
            big = vl;
            big = big <<< al;
            mx  = (132'sd1 <<< (w - 1)) - 132'sd1;
            mn  = -(132'sd1 <<< (w - 1));
            if (big > mx) begin r = mx[63:0]; s = 1'b1; end
            else if (big < mn) begin r = mn[63:0]; s = 1'b1; end
            else r = big[63:0];
        end else begin
            r = 64'(vl >>> (-al));
        end
        r = r & lmask(w);
    endfunction

    function automatic void ref_vec(input logic [1:0] sz, input logic [VLEN-1:0] v,
                                    input logic [VLEN-1:0] a, input logic [NB-1:0] p,
                                    output logic [VLEN-1:0] rv, output logic [NB-1:0] rs);
        int w;
        w  = 8 << sz;
        rv = '0;
        rs = '0;
        for (int l = 0; l < VLEN / w; l++) begin
            logic [63:0] vr, ar, r;
            logic s;
            vr = 64'(v >> (l * w)) & lmask(w);
            ar = 64'(a >> (l * w)) & lmask(w);
            if (p[l * w / 8]) ref_lane(w, vr, ar, r, s);
            else begin r = ar; s = 1'b0; end
            rv = rv | (VLEN'(r) << (l * w));
            rs[l * w / 8] = s;
        end
    endfunction

    // Reference register stage, updated at each rising edge.
    logic            m_valid;
    logic [VLEN-1:0] m_vec;
    logic [NB-1:0]   m_sat;
    string           m_tag;
    always @(posedge clk) begin : model
        logic [VLEN-1:0] tv;
        logic [NB-1:0]   ts;
        if (!rst_n) begin
            m_valid <= 1'b0;
            m_vec   <= '0;
            m_sat   <= '0;
            m_tag   <= "R9";
        end else begin
            m_valid <= in_valid;
            if (in_valid) begin
                ref_vec(size_sel, src_vec, amt_vec, pred, tv, ts);
                m_vec <= tv;
                m_sat <= ts;
                m_tag <= cur_tag;
            end
        end
    end

    // Compare against the model in the middle of every cycle.
    always @(negedge clk) begin
        if (running) begin
            n_tests++;
            if (out_valid !== m_valid) begin
                n_fail++;
                $display("FAIL %s out_valid actual=%0b expected=%0b", rst_n ? "R8" : "R9", out_valid, m_valid);
            end
            n_tests++;
            if (out_vec !== m_vec) begin
                n_fail++;
                $display("FAIL %s out_vec actual=%h expected=%h", m_tag, out_vec, m_vec);
            end
            n_tests++;
            if (out_sat !== m_sat) begin
                n_fail++;
                $display("FAIL %s out_sat actual=%h expected=%h", m_tag, out_sat, m_sat);
            end
        end
    end

    function automatic logic [VLEN-1:0] rep(input logic [1:0] sz, input logic [63:0] x);
        int w;
        logic [VLEN-1:0] v;
        w = 8 << sz;
        v = '0;
        for (int l = 0; l < VLEN / w; l++) v = v | (VLEN'(x & lmask(w)) << (l * w));
        return v;
    endfunction

    task automatic send(input logic [1:0] sz, input logic [VLEN-1:0] v, input logic [VLEN-1:0] a,
                        input logic [NB-1:0] p, input string tag);
        @(posedge clk); #1;
        size_sel = sz; src_vec = v; amt_vec = a; pred = p; cur_tag = tag; in_valid = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            in_valid = 1'b0;
            src_vec  = {VLEN/32{$urandom}};
            amt_vec  = {VLEN/32{$urandom}};
        end
    endtask

    task automatic send_random(input string tag, input bit small_val);
        logic [1:0] sz;
        int w;
        logic [VLEN-1:0] v, a;
        logic [NB-1:0] p;
        sz = 2'($urandom_range(0, 3));
        w  = 8 << sz;
        for (int i = 0; i < VLEN / 32; i++) v[i*32 +: 32] = $urandom;
        a = '0;
        for (int l = 0; l < VLEN / w; l++) begin
            longint x;
            if ($urandom_range(0, 7) == 0) x = {$urandom, $urandom};
            else x = longint'($urandom_range(0, 2 * w + 8)) - longint'(w + 4);
            a = a | (VLEN'(64'(x) & lmask(w)) << (l * w));
            if (small_val) begin
                longint y;
                y = longint'($urandom_range(0, 40)) - 20;
                v[l*w +: 8] = 8'(y);
                for (int b = 8; b < w; b++) v[l*w + b] = y[63];
            end
        end
        p = NB'({$urandom, $urandom});
        send(sz, v, a, p, tag);
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; size_sel = '0;
        src_vec = '0; amt_vec = '0; pred = '0;
        running = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: same small operands at every lane width
        for (int s = 0; s < 4; s++)
            send(2'(s), rep(2'(s), 64'd3), rep(2'(s), 64'd2), '1, "R1");
        // R2: left shifts without overflow
        send(2'b00, rep(2'b00, 64'hFD), rep(2'b00, 64'd4), '1, "R2");
        send(2'b10, rep(2'b10, 64'h0001_2345), rep(2'b10, 64'd7), '1, "R2");
        // R3: right shifts, floor rounding, zero amount
        send(2'b00, rep(2'b00, 64'hF9), rep(2'b00, 64'hFF), '1, "R3");
        send(2'b01, rep(2'b01, 64'h8001), rep(2'b01, 64'hFFFC), '1, "R3");
        send(2'b11, rep(2'b11, 64'h8000_0000_0000_0007), rep(2'b11, 64'd0), '1, "R3");
        // R4: saturation both ways
        send(2'b00, rep(2'b00, 64'h40), rep(2'b00, 64'd2), '1, "R4");
        send(2'b00, rep(2'b00, 64'hC0), rep(2'b00, 64'd2), '1, "R4");
        send(2'b11, rep(2'b11, 64'h4000_0000_0000_0000), rep(2'b11, 64'd1), '1, "R4");
        send(2'b10, rep(2'b10, 64'hFFFF_FFFF), rep(2'b10, 64'd31), '1, "R4");
        // R5: clamped and out-of-range amounts
        send(2'b00, rep(2'b00, 64'h85), rep(2'b00, 64'h80), '1, "R5");
        send(2'b00, rep(2'b00, 64'h05), rep(2'b00, 64'hF8), '1, "R5");
        send(2'b00, rep(2'b00, 64'h00), rep(2'b00, 64'h7F), '1, "R5");
        send(2'b00, rep(2'b00, 64'h01), rep(2'b00, 64'h7F), '1, "R5");
        send(2'b00, rep(2'b00, 64'hFF), rep(2'b00, 64'd9), '1, "R5");
        send(2'b11, rep(2'b11, 64'h1), rep(2'b11, 64'd64), '1, "R5");
        send(2'b11, rep(2'b11, 64'hFFFF_FFFF_FFFF_FFF0), rep(2'b11, 64'h8000_0000_0000_0000), '1, "R5");
        // R6: only the lowest byte of a lane governs it
        send(2'b10, rep(2'b10, 64'h40), rep(2'b10, 64'd3), 16'hEEEE, "R6");
        send(2'b10, rep(2'b10, 64'h40), rep(2'b10, 64'd3), 16'h1111, "R6");
        send(2'b01, rep(2'b01, 64'h7000), rep(2'b01, 64'd5), 16'h5A5A, "R6");
        // R7: mixed flags within one vector
        send(2'b00, 128'h7F01_C000_4002_8001_0000_0000_0000_0010,
                    128'h0101_0102_0202_0303_7F7F_8080_0707_0303, 16'hF0F5, "R7");
        // R8: idle gaps hold the outputs, then back-to-back traffic
        idle(3);
        send(2'b01, rep(2'b01, 64'h1234), rep(2'b01, 64'd1), '1, "R8");
        idle(1);
        for (int i = 0; i < 6; i++) send_random("R8", 1'b1);
        idle(2);
        // R9: reset in the middle of traffic
        send(2'b00, rep(2'b00, 64'h40), rep(2'b00, 64'd2), '1, "R9");
        @(posedge clk); #1 rst_n = 1'b0; in_valid = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        // Random traffic over all widths
        for (int i = 0; i < 400; i++) begin
            if (i % 2 == 0) send_random("R2", 1'b1);
            else send_random("R7", 1'b0);
            if ($urandom_range(0, 4) == 0) idle(1);
        end
        idle(3);
        running = 1'b0;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(8 * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL R8 watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule